// File: doc/BRIEF.md
# Streaming 3x3 Color Matrix Converter

This block converts a stream of three-component pixels from one color space to another. Each output channel is a signed weighted sum of the three input components plus a signed offset. A power-of-two gain is applied to the sum, and the result is rounded to nearest and clamped to the pixel range. With saturation enabled, the clamp is to the video range instead. Pixels enter and leave through valid/ready handshakes. The input carries a start-of-frame marker, and that marker travels with its pixel to the output.

A small write-only register port loads a shadow parameter set: nine coefficients, three offsets, a gain code and a saturation flag. The shadow set is copied into the working set only when a pixel marked as start of frame is accepted. That pixel and every later one use the new set, so a frame never mixes two sets. Loading the right values gives RGB to YCbCr, YCbCr to RGB, or an exact RGB pass-through. The pass-through is also the working set after reset.

Top module: `color_matrix_conv`

## Requirements
- R1: After reset `m_valid` is low, `s_ready` is high, and the working set is the identity: 128 on the diagonal, 0 elsewhere, all offsets 0, gain code 2, saturation off. Pixels therefore pass through unchanged.
- R2: Output channel i equals clamp(round_half_up(2^(g-1) * (sum over j of C[i][j]*x[j] / 256 + O[i] / 4))), where g is the gain code, each C is a 9-bit two's-complement coefficient and each O is a 13-bit two's-complement offset with 2 fractional bits.
- R2 (register map): C[i][j] is written at address 3*i+j with data bits [8:0]. O[i] is written at address 9+i with bits [12:0]. Address 12 takes the gain code in bits [1:0] and the saturation flag in bit 2.
- R3: Coefficients {77,150,29 / -43,-85,128 / 128,-107,-21} with offsets {0,512,512} and gain code 1 produce luma, blue-difference and red-difference outputs per R2.
- R4: Coefficients {149,0,204 / 149,-50,-104 / 149,255,0} with offsets {-446,266,-554} and gain code 2 produce RGB outputs per R2.
- R5: All four gain codes 0 to 3 scale the identity matrix by 1/2, 1, 2 and 4 relative to unity at code 1 over 256, with rounding half up.
- R6: With saturation off, results below 0 give 0 and results above 255 give 255.
- R7: With saturation on, channel 0 is clamped to 16..235 and channels 1 and 2 to 16..240.
- R8: With `m_ready` held high, a pixel accepted at a rising edge is presented with `m_valid` high right after the third rising edge, counting the accepting edge as the first.
- R9: While `m_valid` is high and `m_ready` is low, the output pixel and marker hold steady and `s_ready` is low. No pixel is lost or repeated.
- R10: Register writes change only the shadow set. The working set loads from the shadow set when a pixel with `s_sof` high is accepted, and that pixel already uses the new set.
- R11: Writes to addresses 13 to 15 change neither set.
- R12: `m_sof` is high exactly on the output pixel whose input had `s_sof` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Parameter write strobe |
| cfg_addr | input | 4 | Parameter address |
| cfg_wdata | input | 13 | Parameter write data |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel accepted when high with s_valid |
| s_sof | input | 1 | Input pixel is first of a frame |
| s_c0 | input | 8 | Input component 0 |
| s_c1 | input | 8 | Input component 1 |
| s_c2 | input | 8 | Input component 2 |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream accepts output pixel |
| m_sof | output | 1 | Output pixel is first of a frame |
| m_c0 | output | 8 | Output channel 0 |
| m_c1 | output | 8 | Output channel 1 |
| m_c2 | output | 8 | Output channel 2 |

## Verification
The identity set with random pixels shows whether components are routed to the right channels without distortion. The two conversion sets bring in negative coefficients and negative offsets. Applying them to random pixels and to black, white and saturated primaries separates sign-extension and rounding faults from clamp faults. The saturation flag is run on the same pixels with it on and off, which distinguishes the luma and chroma limits from the full-range clamp. Gain codes 0 and 3 on the identity expose errors in the shift amount. A parameter write in mid-frame, a write to an unused address, and random back-pressure show whether the set switches only on the frame marker and whether stalls keep the stream intact.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
   localparam int CMC_NCH       = 3;
   localparam int CMC_NTAP      = CMC_NCH * CMC_NCH;
   localparam int CMC_COEF_BASE = 0;
   localparam int CMC_OFF_BASE  = CMC_NTAP;
   localparam int CMC_CTRL_ADDR = CMC_OFF_BASE + CMC_NCH;

   // gain applied to (sum of products / 256)
   typedef enum logic [1:0] {
      SCL_X0P5 = 2'd0,
      SCL_X1   = 2'd1,
      SCL_X2   = 2'd2,
      SCL_X4   = 2'd3
   } cmc_scale_e;

   function automatic int cmc_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/cmc_param_bank.sv
module cmc_param_bank
   import cmc_pkg::*;
#(
   parameter int COEF_W = 9,
   parameter int OFF_W  = 13,
   parameter int ADDR_W = 4,
   parameter int CFG_W  = 13
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_we,
   input  logic [ADDR_W-1:0]           cfg_addr,
   input  logic [CFG_W-1:0]            cfg_wdata,
   input  logic                        apply,
   output logic [CMC_NTAP*COEF_W-1:0]  eff_coef,
   output logic [CMC_NCH*OFF_W-1:0]    eff_off,
   output logic [1:0]                  eff_scale,
   output logic                        eff_sat
);
   localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << (COEF_W - 2);

   logic [CMC_NTAP*COEF_W-1:0] sh_coef_flat, act_coef_flat;
   logic [CMC_NCH*OFF_W-1:0]   sh_off_flat, act_off_flat;
   logic [1:0]                 sh_scale, act_scale;
   logic                       sh_sat, act_sat;

   for (genvar t = 0; t < CMC_NTAP; t++) begin : g_coef
      localparam logic [COEF_W-1:0] RST_V = ((t / CMC_NCH) == (t % CMC_NCH)) ? UNITY : '0;
      logic [COEF_W-1:0] sh_q, act_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_q  <= RST_V;
            act_q <= RST_V;
         end else begin
            if (cfg_we && cfg_addr == ADDR_W'(CMC_COEF_BASE + t))
               sh_q <= cfg_wdata[COEF_W-1:0];
            if (apply)
               act_q <= sh_q;
         end
      end
      assign sh_coef_flat[t*COEF_W +: COEF_W]  = sh_q;
      assign act_coef_flat[t*COEF_W +: COEF_W] = act_q;
      assign eff_coef[t*COEF_W +: COEF_W]      = apply ? sh_q : act_q;
   end

   for (genvar c = 0; c < CMC_NCH; c++) begin : g_off
      logic [OFF_W-1:0] sh_q, act_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_q  <= '0;
            act_q <= '0;
         end else begin
            if (cfg_we && cfg_addr == ADDR_W'(CMC_OFF_BASE + c))
               sh_q <= cfg_wdata[OFF_W-1:0];
            if (apply)
               act_q <= sh_q;
         end
      end
      assign sh_off_flat[c*OFF_W +: OFF_W]  = sh_q;
      assign act_off_flat[c*OFF_W +: OFF_W] = act_q;
      assign eff_off[c*OFF_W +: OFF_W]      = apply ? sh_q : act_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_scale  <= SCL_X2;
         sh_sat    <= 1'b0;
         act_scale <= SCL_X2;
         act_sat   <= 1'b0;
      end else begin
         if (cfg_we && cfg_addr == ADDR_W'(CMC_CTRL_ADDR)) begin
            sh_scale <= cfg_wdata[1:0];
            sh_sat   <= cfg_wdata[2];
         end
         if (apply) begin
            act_scale <= sh_scale;
            act_sat   <= sh_sat;
         end
      end
   end

   assign eff_scale = apply ? sh_scale : act_scale;
   assign eff_sat   = apply ? sh_sat   : act_sat;

   // R10
   param_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !apply |=> $stable({act_coef_flat, act_off_flat, act_scale, act_sat}));

   // R11
   unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr > ADDR_W'(CMC_CTRL_ADDR))
      |=> $stable({sh_coef_flat, sh_off_flat, sh_scale, sh_sat}));
endmodule

// File: rtl/cmc_product_stage.sv
module cmc_product_stage
   import cmc_pkg::*;
#(
   parameter int PIX_W  = 8,
   parameter int COEF_W = 9,
   parameter int OFF_W  = 13,
   parameter int PROD_W = COEF_W + PIX_W + 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        adv,
   input  logic                        in_valid,
   input  logic                        in_sof,
   input  logic [CMC_NCH*PIX_W-1:0]    in_pix,
   input  logic [CMC_NTAP*COEF_W-1:0]  in_coef,
   input  logic [CMC_NCH*OFF_W-1:0]    in_off,
   input  logic [1:0]                  in_scale,
   input  logic                        in_sat,
   output logic                        v_q,
   output logic                        sof_q,
   output logic [CMC_NTAP*PROD_W-1:0]  prod_q,
   output logic [CMC_NCH*OFF_W-1:0]    off_q,
   output logic [1:0]                  scale_q,
   output logic                        sat_q
);
   // tap t: output row t/NCH, input column t%NCH
   for (genvar t = 0; t < CMC_NTAP; t++) begin : g_tap
      logic signed [PROD_W-1:0] c_ext, x_ext, p_d, p_q;
      assign c_ext = PROD_W'($signed(in_coef[t*COEF_W +: COEF_W]));
      assign x_ext = PROD_W'({1'b0, in_pix[(t % CMC_NCH)*PIX_W +: PIX_W]});
      assign p_d   = c_ext * x_ext;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   p_q <= '0;
         else if (adv) p_q <= p_d;
      end
      assign prod_q[t*PROD_W +: PROD_W] = p_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q     <= 1'b0;
         sof_q   <= 1'b0;
         off_q   <= '0;
         scale_q <= '0;
         sat_q   <= 1'b0;
      end else if (adv) begin
         v_q     <= in_valid;
         sof_q   <= in_sof & in_valid;
         off_q   <= in_off;
         scale_q <= in_scale;
         sat_q   <= in_sat;
      end
   end
endmodule

// File: rtl/cmc_accum_stage.sv
module cmc_accum_stage
   import cmc_pkg::*;
#(
   parameter int COEF_W   = 9,
   parameter int OFF_W    = 13,
   parameter int OFF_FRAC = 2,
   parameter int PROD_W   = 18,
   parameter int ACC_W    = 22
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        adv,
   input  logic                        in_valid,
   input  logic                        in_sof,
   input  logic [CMC_NTAP*PROD_W-1:0]  in_prod,
   input  logic [CMC_NCH*OFF_W-1:0]    in_off,
   input  logic [1:0]                  in_scale,
   input  logic                        in_sat,
   output logic                        v_q,
   output logic                        sof_q,
   output logic                        sat_q,
   output logic [CMC_NCH*ACC_W-1:0]    res_q
);
   // offset in units of (product / 2^(COEF_W-1))
   localparam int OFF_SH = COEF_W - 1 - OFF_FRAC;

   int unsigned shamt;
   assign shamt = COEF_W - int'(in_scale);

   for (genvar c = 0; c < CMC_NCH; c++) begin : g_ch
      logic signed [ACC_W-1:0] sum, off_ext, rnd, acc, r_q;
      always_comb begin
         sum = '0;
         for (int k = 0; k < CMC_NCH; k++)
            sum = sum + ACC_W'($signed(in_prod[(c*CMC_NCH + k)*PROD_W +: PROD_W]));
         off_ext = ACC_W'($signed(in_off[c*OFF_W +: OFF_W])) <<< OFF_SH;
         rnd     = ACC_W'(1) <<< (shamt - 1);
         acc     = sum + off_ext + rnd;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   r_q <= '0;
         else if (adv) r_q <= acc >>> shamt;
      end
      assign res_q[c*ACC_W +: ACC_W] = r_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q   <= 1'b0;
         sof_q <= 1'b0;
         sat_q <= 1'b0;
      end else if (adv) begin
         v_q   <= in_valid;
         sof_q <= in_sof;
         sat_q <= in_sat;
      end
   end
endmodule

// File: rtl/cmc_clamp_stage.sv
module cmc_clamp_stage
   import cmc_pkg::*;
#(
   parameter int PIX_W    = 8,
   parameter int ACC_W    = 22,
   parameter int SAT_LO   = 16,
   parameter int SAT_HI_Y = 235,
   parameter int SAT_HI_C = 240
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      adv,
   input  logic                      in_valid,
   input  logic                      in_sof,
   input  logic                      in_sat,
   input  logic [CMC_NCH*ACC_W-1:0]  in_res,
   output logic                      v_q,
   output logic                      sof_q,
   output logic [CMC_NCH*PIX_W-1:0]  pix_q
);
   localparam int PIX_MAX = (1 << PIX_W) - 1;
   logic sat_q;

   for (genvar c = 0; c < CMC_NCH; c++) begin : g_ch
      localparam int HI_SAT = (c == 0) ? SAT_HI_Y : SAT_HI_C;
      logic signed [ACC_W-1:0] r, lo, hi;
      logic [PIX_W-1:0]        y_d, y_q;
      assign r  = $signed(in_res[c*ACC_W +: ACC_W]);
      assign lo = in_sat ? ACC_W'(SAT_LO) : '0;
      assign hi = in_sat ? ACC_W'(HI_SAT) : ACC_W'(PIX_MAX);
      always_comb begin
         if (r < lo)      y_d = lo[PIX_W-1:0];
         else if (r > hi) y_d = hi[PIX_W-1:0];
         else             y_d = r[PIX_W-1:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   y_q <= '0;
         else if (adv) y_q <= y_d;
      end
      assign pix_q[c*PIX_W +: PIX_W] = y_q;

      // R7
      sat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (v_q && sat_q) |-> (int'(y_q) >= SAT_LO && int'(y_q) <= HI_SAT));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q   <= 1'b0;
         sof_q <= 1'b0;
         sat_q <= 1'b0;
      end else if (adv) begin
         v_q   <= in_valid;
         sof_q <= in_sof;
         sat_q <= in_sat;
      end
   end
endmodule

// File: rtl/color_matrix_conv.sv
module color_matrix_conv
   import cmc_pkg::*;
#(
   parameter int PIX_W    = 8,
   parameter int COEF_W   = 9,
   parameter int OFF_W    = 13,
   parameter int OFF_FRAC = 2,
   parameter int ADDR_W   = 4,
   parameter int SAT_LO   = 16,
   parameter int SAT_HI_Y = 235,
   parameter int SAT_HI_C = 240
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   cfg_we,
   input  logic [ADDR_W-1:0]                      cfg_addr,
   input  logic [cmc_max(cmc_max(OFF_W, COEF_W), 3)-1:0] cfg_wdata,
   input  logic                                   s_valid,
   output logic                                   s_ready,
   input  logic                                   s_sof,
   input  logic [PIX_W-1:0]                       s_c0,
   input  logic [PIX_W-1:0]                       s_c1,
   input  logic [PIX_W-1:0]                       s_c2,
   output logic                                   m_valid,
   input  logic                                   m_ready,
   output logic                                   m_sof,
   output logic [PIX_W-1:0]                       m_c0,
   output logic [PIX_W-1:0]                       m_c1,
   output logic [PIX_W-1:0]                       m_c2
);
   localparam int CFG_W  = cmc_max(cmc_max(OFF_W, COEF_W), 3);
   localparam int PROD_W = COEF_W + PIX_W + 1;
   localparam int ACC_W  = cmc_max(PROD_W + 2, OFF_W + COEF_W - 1 - OFF_FRAC) + 2;

   if (COEF_W < 4 || OFF_FRAC < 0 || OFF_FRAC > COEF_W - 1) begin : g_bad_coef
      $error("color_matrix_conv: coefficient or offset format out of range");
   end
   if ((1 << ADDR_W) <= CMC_CTRL_ADDR) begin : g_bad_addr
      $error("color_matrix_conv: address width too small for parameter map");
   end
   if (SAT_HI_Y > (1 << PIX_W) - 1 || SAT_HI_C > (1 << PIX_W) - 1 || SAT_LO < 0) begin : g_bad_sat
      $error("color_matrix_conv: video-range limits exceed pixel range");
   end

   logic adv, apply;
   assign adv     = !m_valid || m_ready;
   assign s_ready = adv;
   assign apply   = s_valid && adv && s_sof;

   logic [CMC_NTAP*COEF_W-1:0] eff_coef;
   logic [CMC_NCH*OFF_W-1:0]   eff_off;
   logic [1:0]                 eff_scale;
   logic                       eff_sat;

   cmc_param_bank #(.COEF_W(COEF_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .CFG_W(CFG_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .apply(apply), .eff_coef(eff_coef), .eff_off(eff_off), .eff_scale(eff_scale),
      .eff_sat(eff_sat)
   );

   logic                       v1, sof1, sat1;
   logic [CMC_NTAP*PROD_W-1:0] prod1;
   logic [CMC_NCH*OFF_W-1:0]   off1;
   logic [1:0]                 scale1;

   cmc_product_stage #(.PIX_W(PIX_W), .COEF_W(COEF_W), .OFF_W(OFF_W), .PROD_W(PROD_W)) u_mul (
      .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(s_valid), .in_sof(s_sof),
      .in_pix({s_c2, s_c1, s_c0}), .in_coef(eff_coef), .in_off(eff_off),
      .in_scale(eff_scale), .in_sat(eff_sat),
      .v_q(v1), .sof_q(sof1), .prod_q(prod1), .off_q(off1), .scale_q(scale1), .sat_q(sat1)
   );

   logic                     v2, sof2, sat2;
   logic [CMC_NCH*ACC_W-1:0] res2;

   cmc_accum_stage #(.COEF_W(COEF_W), .OFF_W(OFF_W), .OFF_FRAC(OFF_FRAC),
                     .PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(v1), .in_sof(sof1),
      .in_prod(prod1), .in_off(off1), .in_scale(scale1), .in_sat(sat1),
      .v_q(v2), .sof_q(sof2), .sat_q(sat2), .res_q(res2)
   );

   logic [CMC_NCH*PIX_W-1:0] pix3;

   cmc_clamp_stage #(.PIX_W(PIX_W), .ACC_W(ACC_W), .SAT_LO(SAT_LO),
                     .SAT_HI_Y(SAT_HI_Y), .SAT_HI_C(SAT_HI_C)) u_clamp (
      .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(v2), .in_sof(sof2), .in_sat(sat2),
      .in_res(res2), .v_q(m_valid), .sof_q(m_sof), .pix_q(pix3)
   );

   assign m_c0 = pix3[0*PIX_W +: PIX_W];
   assign m_c1 = pix3[1*PIX_W +: PIX_W];
   assign m_c2 = pix3[2*PIX_W +: PIX_W];

   // R9
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable({m_c0, m_c1, m_c2, m_sof})));

   // R12
   sof_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_sof |-> m_valid);
endmodule

// File: tb/color_matrix_conv_bench.sv
module color_matrix_conv_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [3:0] cfg_addr = '0;
   logic [12:0] cfg_wdata = '0;
   logic       s_valid = 1'b0, s_sof = 1'b0, m_ready = 1'b0;
   logic [7:0] s_c0 = '0, s_c1 = '0, s_c2 = '0;
   logic       s_ready, m_valid, m_sof;
   logic [7:0] m_c0, m_c1, m_c2;

   always #2 clk = ~clk;

   color_matrix_conv u_color_matrix_conv (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .s_valid(s_valid), .s_ready(s_ready), .s_sof(s_sof), .s_c0(s_c0), .s_c1(s_c1), .s_c2(s_c2),
      .m_valid(m_valid), .m_ready(m_ready), .m_sof(m_sof), .m_c0(m_c0), .m_c1(m_c1), .m_c2(m_c2)
   );

   int n_tests = 0, n_fail = 0;
   bit done = 0;
   string cur_req = "R1";

   int sh_coef[9], act_coef[9], sh_off[3], act_off[3];
   int sh_scale, act_scale, sh_sat, act_sat;
   int    exp_q[$];
   string req_q[$];

   task automatic check(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int sext(input int v, input int w);
      int m = v & ((1 << w) - 1);
      if (m >= (1 << (w - 1))) m = m - (1 << w);
      return m;
   endfunction

   // model of R2, R6, R7 on the working set
   function automatic int ref_ch(input int ch, input int x0, input int x1, input int x2);
      int x[3];
      int acc, sh, r, lo, hi;
      x[0] = x0; x[1] = x1; x[2] = x2;
      acc = act_off[ch] * 64;
      for (int k = 0; k < 3; k++) acc += act_coef[ch*3 + k] * x[k];
      sh = 9 - act_scale;
      r  = (acc + (1 << (sh - 1))) >>> sh;
      lo = act_sat ? 16 : 0;
      hi = act_sat ? ((ch == 0) ? 235 : 240) : 255;
      if (r < lo) r = lo;
      if (r > hi) r = hi;
      return r;
   endfunction

   function automatic void model_reset();
      for (int t = 0; t < 9; t++) begin
         sh_coef[t]  = ((t / 3) == (t % 3)) ? 128 : 0;
         act_coef[t] = sh_coef[t];
      end
      for (int c = 0; c < 3; c++) begin sh_off[c] = 0; act_off[c] = 0; end
      sh_scale = 2; act_scale = 2; sh_sat = 0; act_sat = 0;
   endfunction

   task automatic cycle(input bit vin, input bit sof, input int x0, input int x1, input int x2,
                        input bit rdy, input bit we = 0, input int addr = 0, input int data = 0);
      int e;
      string r;
      @(negedge clk);
      s_valid = vin; s_sof = sof; s_c0 = 8'(x0); s_c1 = 8'(x1); s_c2 = 8'(x2);
      m_ready = rdy; cfg_we = we; cfg_addr = 4'(addr); cfg_wdata = 13'(data);
      #1;
      if (m_valid && m_ready) begin
         if (exp_q.size() == 0) begin
            check("R9", "unexpected output pixel", 1, 0);
         end else begin
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check(r, "ch0", int'(m_c0), e & 255);
            check(r, "ch1", int'(m_c1), (e >> 8) & 255);
            check(r, "ch2", int'(m_c2), (e >> 16) & 255);
            check("R12", "sof marker", int'(m_sof), (e >> 24) & 1);
         end
      end
      if (s_valid && s_ready) begin
         if (sof) begin
            act_coef = sh_coef; act_off = sh_off; act_scale = sh_scale; act_sat = sh_sat;
         end
         exp_q.push_back(ref_ch(0, x0, x1, x2) | (ref_ch(1, x0, x1, x2) << 8) |
                         (ref_ch(2, x0, x1, x2) << 16) | (int'(sof) << 24));
         req_q.push_back(cur_req);
      end
      if (we) begin
         if (addr < 9)       sh_coef[addr] = sext(data, 9);
         else if (addr < 12) sh_off[addr-9] = sext(data, 13);
         else if (addr == 12) begin sh_scale = data & 3; sh_sat = (data >> 2) & 1; end
      end
   endtask

   task automatic wr(input int addr, input int data);
      cycle(0, 0, 0, 0, 0, 1, 1, addr, data);
   endtask

   task automatic load_set(input int c[9], input int o[3], input int scl, input int sat);
      for (int t = 0; t < 9; t++) wr(t, c[t]);
      for (int k = 0; k < 3; k++) wr(9 + k, o[k]);
      wr(12, scl | (sat << 2));
   endtask

   task automatic drain();
      for (int i = 0; i < 8; i++) cycle(0, 0, 0, 0, 0, 1);
   endtask

   task automatic rand_burst(input int n, input bit rand_rdy);
      for (int i = 0; i < n; i++)
         cycle(($urandom % 5) != 0, 0, $urandom % 256, $urandom % 256, $urandom % 256,
               rand_rdy ? (($urandom % 4) != 0) : 1'b1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int rgb2yuv_c[9] = '{77, 150, 29, -43, -85, 128, 128, -107, -21};
      int rgb2yuv_o[3] = '{0, 512, 512};
      int yuv2rgb_c[9] = '{149, 0, 204, 149, -50, -104, 149, 255, 0};
      int yuv2rgb_o[3] = '{-446, 266, -554};
      int ident_c[9]   = '{128, 0, 0, 0, 128, 0, 0, 0, 128};
      int zero_o[3]    = '{0, 0, 0};
      int h0, h1, h2;
      void'($urandom(32'h00C5_C0DE));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state
      check("R1", "m_valid after reset", int'(m_valid), 0);
      check("R1", "s_ready after reset", int'(s_ready), 1);

      // R1 identity pass-through before any write
      cur_req = "R1";
      cycle(1, 0, 10, 200, 37, 1);
      cycle(1, 0, 255, 0, 128, 1);
      drain();

      // R8 latency
      cur_req = "R8";
      cycle(1, 0, 5, 6, 7, 1);
      cycle(0, 0, 0, 0, 0, 1); check("R8", "m_valid after 1st edge", int'(m_valid), 0);
      cycle(0, 0, 0, 0, 0, 1); check("R8", "m_valid after 2nd edge", int'(m_valid), 0);
      cycle(0, 0, 0, 0, 0, 1); check("R8", "m_valid after 3rd edge", int'(m_valid), 1);
      drain();

      // R2 identity under random traffic
      cur_req = "R2";
      cycle(1, 1, 1, 2, 3, 1);
      rand_burst(40, 0);
      drain();

      // R3 RGB to YCbCr with directed primaries and random stalls (R9)
      load_set(rgb2yuv_c, rgb2yuv_o, 1, 0);
      cur_req = "R3";
      cycle(1, 1, 255, 255, 255, 1);
      cycle(1, 0, 0, 0, 0, 1);
      cycle(1, 0, 255, 0, 0, 1);
      cycle(1, 0, 0, 0, 255, 1);
      cur_req = "R9";
      rand_burst(60, 1);
      drain();

      // R7 saturation on the same set
      wr(12, 1 | (1 << 2));
      cur_req = "R7";
      cycle(1, 1, 255, 255, 255, 1);
      cycle(1, 0, 0, 0, 0, 1);
      cycle(1, 0, 0, 0, 255, 1);
      cycle(1, 0, 255, 0, 0, 1);
      rand_burst(40, 1);
      drain();

      // R4 YCbCr to RGB, R6 full-range clamp
      load_set(yuv2rgb_c, yuv2rgb_o, 2, 0);
      cur_req = "R6";
      cycle(1, 1, 255, 255, 255, 1);
      cycle(1, 0, 0, 0, 0, 1);
      cycle(1, 0, 255, 0, 255, 1);
      cur_req = "R4";
      cycle(1, 0, 128, 128, 128, 1);
      cycle(1, 0, 81, 90, 240, 1);
      rand_burst(50, 1);
      drain();

      // R5 gain codes on the identity
      load_set(ident_c, zero_o, 0, 0);
      cur_req = "R5";
      cycle(1, 1, 1, 2, 255, 1);
      cycle(1, 0, 3, 6, 201, 1);
      rand_burst(15, 0);
      wr(12, 3);
      cycle(1, 1, 100, 127, 128, 1);
      rand_burst(15, 0);
      wr(12, 1);
      cycle(1, 1, 1, 3, 255, 1);
      rand_burst(15, 0);
      drain();

      // R10 mid-frame write waits for the next frame marker
      wr(12, 2);
      cycle(1, 1, 9, 9, 9, 1);
      cur_req = "R10";
      wr(0, 0);
      wr(12, 3);
      cycle(1, 0, 50, 60, 70, 1);
      cycle(1, 0, 200, 100, 40, 1);
      cycle(1, 1, 50, 60, 70, 1);
      cycle(1, 0, 200, 100, 40, 1);
      drain();

      // R11 writes to unused addresses
      load_set(ident_c, zero_o, 2, 0);
      cycle(1, 1, 11, 22, 33, 1);
      cur_req = "R11";
      wr(13, 13'h1FFF);
      wr(14, 13'h0AAA);
      wr(15, 13'h1555);
      cycle(1, 1, 44, 55, 66, 1);
      cycle(1, 0, 77, 88, 99, 1);
      drain();

      // R9 directed stall: outputs hold, input blocked
      cur_req = "R9";
      for (int i = 0; i < 4; i++) cycle(1, i == 0, 10 * i + 1, 10 * i + 2, 10 * i + 3, 0);
      check("R9", "m_valid under stall", int'(m_valid), 1);
      h0 = m_c0; h1 = m_c1; h2 = m_c2;
      for (int i = 0; i < 4; i++) begin
         cycle(1, 0, 99, 98, 97, 0);
         check("R9", "s_ready under stall", int'(s_ready), 0);
         check("R9", "ch0 held", int'(m_c0), h0);
         check("R9", "ch1 held", int'(m_c1), h1);
         check("R9", "ch2 held", int'(m_c2), h2);
      end
      drain();
      check("R9", "pixels left unmatched", exp_q.size(), 0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule